// File: doc/BRIEF.md
# Packet Dispatch Lookup

This block picks the processing handler for each incoming packet. A header parser presents three fields per packet: the protocol number, the destination IPv4 address and the destination port. The block walks its rule table from the lowest index upward, stops at the first rule that fits, and queues a verdict. Each verdict carries a reason code, a handler number and a slot number, and verdicts leave in the same order as the headers came in. The lookup starts as soon as the three fields are handed over, so the payload can still be arriving while the search runs.

Each rule holds a protocol, a port, an address and a 32-bit netmask, so a single rule can cover a whole subnet. The handler's readiness is taken from two plain status vectors. One says which handlers are present on the device. The other says which handler input buffers are full. A packet whose handler is absent is also announced on a one-cycle statistics pulse. Rules are added and removed through a command queue. Additions take table entries from a free-entry list, and removals give entries back to that list. The table is stored as a dual-port RAM, with one port reading for lookups and the other writing for maintenance.

Back-pressure: a header transfers when `hdr_valid` and `hdr_ready` are both high on a rising edge. A command transfers on `cmd_valid` and `cmd_ready` in the same way. A verdict leaves on `res_valid` and `res_ready`. The source must hold a header or command stable while its valid is high and ready is low. `hdr_ready` is low while a search is running, while any command is waiting, and while the verdict queue is full. `cmd_ready` is low only while the command queue is full.

Top module: `pkt_dispatch_lookup`

## Requirements
- R1: A live rule fits a header when the protocols are equal, the ports are equal and `(hdr_dst_ip & mask) == (rule_ip & mask)`, using the rule's own 32-bit mask. A delivered verdict then reports that rule's handler and slot.
- R2: When several live rules fit a header, the verdict comes from the rule with the lowest table index.
- R3: When no live rule fits, the verdict has reason code 1 (no match).
- R4: When the fitting rule's handler has its `hdl_loaded` bit low, the verdict has reason code 3 (not loaded). In the cycle that verdict is queued, `stat_valid` pulses for one cycle with `stat_handler` set to that handler. This outcome takes precedence over a full buffer.
- R5: When the handler is loaded but its `hdl_full` bit is high, the verdict has reason code 2 (buffer full).
- R6: When the handler is loaded and its buffer is not full, the verdict has reason code 0 (deliver). Code 0 is the only outcome that reports no drop.
- R7: Every accepted header yields exactly one verdict, and verdicts leave in header order. While `res_ready` is low, verdicts stay queued. Once RES_DEPTH verdicts are waiting, `hdr_ready` stays low.
- R8: An add command (`cmd_op`=0) takes a free entry and answers with a one-cycle `done_valid` pulse carrying `done_ok`=1 and the entry number on `done_index`. Entries never used since reset are handed out first, in ascending order. After those, freed entries are handed out in the order they were freed. When no entry is free, the add answers `done_ok`=0 and writes nothing.
- R9: A delete command (`cmd_op`=1, entry given by `cmd_index`) kills a live rule and answers `done_ok`=1. A delete of an entry that is already empty answers `done_ok`=0 and leaves the table unchanged.
- R10: Commands run only between searches. A command that arrives while a search is running does not affect that search's verdict. It does affect every search accepted after its `done_valid` pulse.
- R11: After reset, no verdict is pending, `hdr_ready` and `cmd_ready` are high, and the table is empty, so every lookup yields reason code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header fields valid |
| hdr_ready | output | 1 | Header accepted when high |
| hdr_proto | input | 8 | Protocol number |
| hdr_dst_ip | input | 32 | Destination IPv4 address |
| hdr_dst_port | input | 16 | Destination port |
| hdl_loaded | input | 2**HID_W | Per-handler present flag |
| hdl_full | input | 2**HID_W | Per-handler input buffer full flag |
| res_valid | output | 1 | Verdict available |
| res_ready | input | 1 | Verdict consumer ready |
| res_reason | output | 2 | 0 deliver, 1 no match, 2 buffer full, 3 not loaded |
| res_handler | output | HID_W | Handler of the fitting rule (0 on no match) |
| res_slot | output | SLOT_W | Slot of the fitting rule (0 on no match) |
| stat_valid | output | 1 | Pulse: packet dropped for an absent handler |
| stat_handler | output | HID_W | Handler named by the statistics pulse |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high |
| cmd_op | input | 1 | 0 add, 1 delete |
| cmd_index | input | clog2(N_RULES) | Entry to delete |
| cmd_proto | input | 8 | Rule protocol |
| cmd_ip | input | 32 | Rule address |
| cmd_mask | input | 32 | Rule netmask |
| cmd_port | input | 16 | Rule port |
| cmd_handler | input | HID_W | Rule handler |
| cmd_slot | input | SLOT_W | Rule slot |
| done_valid | output | 1 | Command completion pulse |
| done_ok | output | 1 | Command succeeded |
| done_index | output | clog2(N_RULES) | Entry written or freed |

## Verification
The sweep checks every combination of a set of addresses, protocols and ports against overlapping rules. Some of these rules shadow others, and the sweep runs under four patterns of the handler status vectors. Each sweep runs once on the full table and again after deletions and re-adds. A search that did not stop at the lowest fitting index would report a shadowed rule's handler. A design that checked buffer-full before not-loaded would report code 2 where code 3 is due. Free-list order is checked by deleting two entries and re-adding. Recycling in the wrong order, or double-freeing an empty entry, would show up as a wrong `done_index` or a wrong `done_ok`. A delete is posted while a search is running, and the back-pressure check fills the verdict queue. A design that let a write leak into a running search would fail the first of these, and one that dropped or reordered verdicts would fail the second.

// File: rtl/dl_pkg.sv
package dl_pkg;

  typedef enum logic [1:0] {
    RSN_DELIVER  = 2'd0,
    RSN_NOMATCH  = 2'd1,
    RSN_BUFFULL  = 2'd2,
    RSN_UNLOADED = 2'd3
  } reason_e;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_DEL = 1'b1
  } cmd_op_e;

  typedef struct packed {
    logic [7:0]  proto;
    logic [31:0] ip;
    logic [15:0] port;
  } pkt_key_t;

endpackage

// File: rtl/dl_fifo.sv
module dl_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);
  localparam logic [PW:0]   FULL_C = (PW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  assign full  = (cnt == FULL_C);
  assign empty = (cnt == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST_P) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST_P) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/dl_rule_ram.sv
module dl_rule_ram #(
  parameter int AW = 10,
  parameter int W  = 96
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  localparam int ENTRIES = 1 << AW;

  logic [W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/dl_free_list.sv
module dl_free_list #(
  parameter int N  = 1024,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  output logic          avail,
  output logic [AW-1:0] idx,
  input  logic          give,
  input  logic [AW-1:0] give_idx
);
  localparam logic [AW:0] N_C = (AW+1)'(N);

  logic [AW:0]   fresh;
  logic          fresh_left;
  logic          rec_empty, rec_full, rec_pop;
  logic [AW-1:0] rec_dout;

  assign fresh_left = (fresh < N_C);
  assign avail      = fresh_left || !rec_empty;
  assign idx        = fresh_left ? fresh[AW-1:0] : rec_dout;
  assign rec_pop    = take && !fresh_left && !rec_empty;

  always_ff @(posedge clk) begin
    if (!rst_n)                    fresh <= '0;
    else if (take && fresh_left)   fresh <= fresh + 1'b1;
  end

  dl_fifo #(.W(AW), .DEPTH(N)) u_recycle (
    .clk(clk), .rst_n(rst_n),
    .push(give), .din(give_idx),
    .pop(rec_pop), .dout(rec_dout),
    .full(rec_full), .empty(rec_empty)
  );

  // R8
  recycle_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    give |-> !rec_full);

endmodule

// File: rtl/dl_match.sv
module dl_match
  import dl_pkg::*;
(
  input  pkt_key_t    key,
  input  logic [7:0]  r_proto,
  input  logic [31:0] r_ip,
  input  logic [31:0] r_mask,
  input  logic [15:0] r_port,
  output logic        hit
);
  logic net_eq;

  assign net_eq = ((key.ip ^ r_ip) & r_mask) == 32'd0;
  assign hit    = net_eq && (key.proto == r_proto) && (key.port == r_port);

endmodule

// File: rtl/pkt_dispatch_lookup.sv
module pkt_dispatch_lookup
  import dl_pkg::*;
#(
  parameter int N_RULES   = 1024,
  parameter int HID_W     = 4,
  parameter int SLOT_W    = 4,
  parameter int RES_DEPTH = 8,
  parameter int CMD_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hdr_valid,
  output logic                        hdr_ready,
  input  logic [7:0]                  hdr_proto,
  input  logic [31:0]                 hdr_dst_ip,
  input  logic [15:0]                 hdr_dst_port,
  input  logic [(1<<HID_W)-1:0]       hdl_loaded,
  input  logic [(1<<HID_W)-1:0]       hdl_full,
  output logic                        res_valid,
  input  logic                        res_ready,
  output logic [1:0]                  res_reason,
  output logic [HID_W-1:0]            res_handler,
  output logic [SLOT_W-1:0]           res_slot,
  output logic                        stat_valid,
  output logic [HID_W-1:0]            stat_handler,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic                        cmd_op,
  input  logic [$clog2(N_RULES)-1:0]  cmd_index,
  input  logic [7:0]                  cmd_proto,
  input  logic [31:0]                 cmd_ip,
  input  logic [31:0]                 cmd_mask,
  input  logic [15:0]                 cmd_port,
  input  logic [HID_W-1:0]            cmd_handler,
  input  logic [SLOT_W-1:0]           cmd_slot,
  output logic                        done_valid,
  output logic                        done_ok,
  output logic [$clog2(N_RULES)-1:0]  done_index
);
  localparam int AW = $clog2(N_RULES);
  localparam logic [AW:0]   N_C      = (AW+1)'(N_RULES);
  localparam logic [AW-1:0] LAST_IDX = AW'(N_RULES - 1);

  typedef struct packed {
    logic [7:0]        proto;
    logic [31:0]       ip;
    logic [31:0]       mask;
    logic [15:0]       port;
    logic [HID_W-1:0]  hid;
    logic [SLOT_W-1:0] slot;
  } rule_t;

  typedef struct packed {
    logic          op;
    logic [AW-1:0] index;
    rule_t         rule;
  } cmd_t;

  typedef struct packed {
    logic [1:0]        reason;
    logic [HID_W-1:0]  hid;
    logic [SLOT_W-1:0] slot;
  } res_t;

  typedef enum logic {ST_IDLE, ST_SCAN} state_e;

  // ---------------- command queue and execution ----------------
  cmd_t   cq_in, cq;
  logic   cq_full, cq_empty, exec;
  state_e state;

  assign cq_in = '{op: cmd_op, index: cmd_index,
                   rule: '{proto: cmd_proto, ip: cmd_ip, mask: cmd_mask,
                           port: cmd_port, hid: cmd_handler, slot: cmd_slot}};
  assign cmd_ready = !cq_full;

  dl_fifo #(.W($bits(cmd_t)), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n),
    .push(cmd_valid && cmd_ready), .din(cq_in),
    .pop(exec), .dout(cq),
    .full(cq_full), .empty(cq_empty)
  );

  // commands run only while no search is in flight
  assign exec = !cq_empty && (state == ST_IDLE);

  logic [N_RULES-1:0] rule_live;
  logic               op_add, op_del, alloc_ok, tbl_wr, give;
  logic [AW-1:0]      alloc_idx;

  assign op_add = exec && (cq.op == OP_ADD);
  assign op_del = exec && (cq.op == OP_DEL);
  assign tbl_wr = op_add && alloc_ok;
  assign give   = op_del && rule_live[cq.index];

  dl_free_list #(.N(N_RULES), .AW(AW)) u_free (
    .clk(clk), .rst_n(rst_n),
    .take(op_add), .avail(alloc_ok), .idx(alloc_idx),
    .give(give), .give_idx(cq.index)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rule_live  <= '0;
      done_valid <= 1'b0;
      done_ok    <= 1'b0;
      done_index <= '0;
    end else begin
      if (tbl_wr) rule_live[alloc_idx] <= 1'b1;
      if (give)   rule_live[cq.index]  <= 1'b0;
      done_valid <= exec;
      if (exec) begin
        done_ok    <= op_add ? alloc_ok : rule_live[cq.index];
        done_index <= op_add ? alloc_idx : cq.index;
      end
    end
  end

  // ---------------- rule storage ----------------
  logic          rd_en;
  logic [AW:0]   issue_ptr;
  rule_t         cur;

  dl_rule_ram #(.AW(AW), .W($bits(rule_t))) u_table (
    .clk(clk),
    .wr_en(tbl_wr), .wr_addr(alloc_idx), .wr_data(cq.rule),
    .rd_en(rd_en), .rd_addr(issue_ptr[AW-1:0]), .rd_data(cur)
  );

  // ---------------- search engine ----------------
  pkt_key_t      key_q;
  logic          pv, plive, hit, decide, hdr_fire;
  logic [AW-1:0] pidx;
  logic          rq_full, rq_empty, res_push;
  res_t          res_in, res_out;

  assign hdr_ready = (state == ST_IDLE) && cq_empty && !rq_full;
  assign hdr_fire  = hdr_valid && hdr_ready;
  assign rd_en     = (state == ST_SCAN) && (issue_ptr < N_C);

  dl_match u_match (
    .key(key_q), .r_proto(cur.proto), .r_ip(cur.ip),
    .r_mask(cur.mask), .r_port(cur.port), .hit(hit)
  );

  logic fits;
  assign fits   = pv && plive && hit;
  assign decide = (state == ST_SCAN) && (fits || (pv && pidx == LAST_IDX));

  always_comb begin
    res_in = '0;
    if (!fits)                     res_in.reason = RSN_NOMATCH;
    else begin
      res_in.hid  = cur.hid;
      res_in.slot = cur.slot;
      if (!hdl_loaded[cur.hid])    res_in.reason = RSN_UNLOADED;
      else if (hdl_full[cur.hid])  res_in.reason = RSN_BUFFULL;
      else                         res_in.reason = RSN_DELIVER;
    end
  end

  assign res_push     = decide;
  assign stat_valid   = decide && fits && !hdl_loaded[cur.hid];
  assign stat_handler = cur.hid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      issue_ptr <= '0;
      pv        <= 1'b0;
      plive     <= 1'b0;
      pidx      <= '0;
      key_q     <= '0;
    end else if (hdr_fire) begin
      key_q     <= '{proto: hdr_proto, ip: hdr_dst_ip, port: hdr_dst_port};
      issue_ptr <= '0;
      pv        <= 1'b0;
      state     <= ST_SCAN;
    end else if (state == ST_SCAN) begin
      if (decide) begin
        state <= ST_IDLE;
        pv    <= 1'b0;
      end else begin
        pv <= rd_en;
        if (rd_en) begin
          pidx      <= issue_ptr[AW-1:0];
          plive     <= rule_live[issue_ptr[AW-1:0]];
          issue_ptr <= issue_ptr + 1'b1;
        end
      end
    end
  end

  // ---------------- verdict queue ----------------
  dl_fifo #(.W($bits(res_t)), .DEPTH(RES_DEPTH)) u_resq (
    .clk(clk), .rst_n(rst_n),
    .push(res_push), .din(res_in),
    .pop(res_valid && res_ready), .dout(res_out),
    .full(rq_full), .empty(rq_empty)
  );

  assign res_valid   = !rq_empty;
  assign res_reason  = res_out.reason;
  assign res_handler = res_out.hid;
  assign res_slot    = res_out.slot;

  // R10
  wr_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |-> (state == ST_IDLE));

  // R8
  alloc_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |-> !rule_live[alloc_idx]);

  // R9
  del_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    give |=> !rule_live[$past(cq.index)]);

  // R7
  one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_fire |=> !hdr_ready);

endmodule

// File: tb/pkt_dispatch_lookup_test.sv
module pkt_dispatch_lookup_test;
  localparam int NR = 8;
  localparam int HW = 2;
  localparam int SW = 3;
  localparam int RD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic hdr_valid = 0, hdr_ready;
  logic [7:0] hdr_proto = 0;
  logic [31:0] hdr_dst_ip = 0;
  logic [15:0] hdr_dst_port = 0;
  logic [3:0] hdl_loaded = 4'hF, hdl_full = 4'h0;
  logic res_valid, res_ready = 0;
  logic [1:0] res_reason;
  logic [HW-1:0] res_handler, stat_handler;
  logic [SW-1:0] res_slot;
  logic stat_valid;
  logic cmd_valid = 0, cmd_ready, cmd_op = 0;
  logic [2:0] cmd_index = 0;
  logic [7:0] cmd_proto = 0;
  logic [31:0] cmd_ip = 0, cmd_mask = 0;
  logic [15:0] cmd_port = 0;
  logic [HW-1:0] cmd_handler = 0;
  logic [SW-1:0] cmd_slot = 0;
  logic done_valid, done_ok;
  logic [2:0] done_index;

  pkt_dispatch_lookup #(.N_RULES(NR), .HID_W(HW), .SLOT_W(SW),
                        .RES_DEPTH(RD), .CMD_DEPTH(4)) uut (.*);

  int checks = 0, fails = 0;
  int stat_cnt = 0, stat_last = 0;

  // bench model of the table
  bit m_live[NR];
  logic [31:0] m_ip[NR], m_mask[NR];
  logic [7:0] m_proto[NR];
  logic [15:0] m_port[NR];
  int m_hid[NR], m_slot[NR];
  int fresh = 0;
  int freed_q[$];

  always @(negedge clk) if (stat_valid) begin
    stat_cnt++;
    stat_last = int'(stat_handler);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic send_cmd(input bit op, input int idx, input logic [7:0] pr,
                          input logic [31:0] ip, input logic [31:0] mk,
                          input logic [15:0] pt, input int h, input int s);
    @(negedge clk);
    cmd_op = op; cmd_index = 3'(idx); cmd_proto = pr; cmd_ip = ip;
    cmd_mask = mk; cmd_port = pt; cmd_handler = HW'(h); cmd_slot = SW'(s);
    cmd_valid = 1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_done(output bit ok, output int idx);
    while (!done_valid) @(negedge clk);
    ok = done_ok; idx = int'(done_index);
    @(negedge clk);
  endtask

  // R8: add with allocation order modelled in the bench
  task automatic add_rule(input logic [7:0] pr, input logic [31:0] ip,
                          input logic [31:0] mk, input logic [15:0] pt,
                          input int h, input int s);
    int e_idx; bit e_ok; bit ok; int idx;
    if (fresh < NR) begin e_ok = 1; e_idx = fresh; fresh++; end
    else if (freed_q.size() > 0) begin e_ok = 1; e_idx = freed_q.pop_front(); end
    else begin e_ok = 0; e_idx = -1; end
    send_cmd(1'b0, 0, pr, ip, mk, pt, h, s);
    wait_done(ok, idx);
    chk(ok == e_ok, "R8", "add ok", ok, e_ok);
    if (e_ok) begin
      chk(idx == e_idx, "R8", "add index", idx, e_idx);
      m_live[e_idx] = 1; m_ip[e_idx] = ip; m_mask[e_idx] = mk;
      m_proto[e_idx] = pr; m_port[e_idx] = pt; m_hid[e_idx] = h; m_slot[e_idx] = s;
    end
  endtask

  // R9: delete
  task automatic del_rule(input int idx_in);
    bit ok; int idx; bit e_ok;
    e_ok = m_live[idx_in];
    send_cmd(1'b1, idx_in, 0, 0, 0, 0, 0, 0);
    wait_done(ok, idx);
    chk(ok == e_ok, "R9", "delete ok", ok, e_ok);
    if (e_ok) begin m_live[idx_in] = 0; freed_q.push_back(idx_in); end
  endtask

  // R1/R2: lowest live fitting index; R3..R6 reason codes
  task automatic expect_res(input logic [7:0] pr, input logic [31:0] ip,
                            input logic [15:0] pt,
                            output int rsn, output int h, output int s);
    int hitidx = -1;
    for (int i = NR - 1; i >= 0; i--)
      if (m_live[i] && m_proto[i] == pr && m_port[i] == pt &&
          ((ip ^ m_ip[i]) & m_mask[i]) == 32'd0) hitidx = i;
    h = 0; s = 0;
    if (hitidx < 0) rsn = 1;
    else begin
      h = m_hid[hitidx]; s = m_slot[hitidx];
      if (!hdl_loaded[h]) rsn = 3;
      else if (hdl_full[h]) rsn = 2;
      else rsn = 0;
    end
  endtask

  task automatic send_hdr(input logic [7:0] pr, input logic [31:0] ip,
                          input logic [15:0] pt);
    @(negedge clk);
    hdr_proto = pr; hdr_dst_ip = ip; hdr_dst_port = pt; hdr_valid = 1;
    while (!hdr_ready) @(negedge clk);
    @(negedge clk);
    hdr_valid = 0;
  endtask

  task automatic get_res(output int rsn, output int h, output int s);
    res_ready = 1;
    while (!res_valid) @(negedge clk);
    rsn = int'(res_reason); h = int'(res_handler); s = int'(res_slot);
    @(negedge clk);
    res_ready = 0;
  endtask

  task automatic cmp_res(input int rsn, input int h, input int s,
                         input int ersn, input int eh, input int es);
    string tag;
    case (ersn)
      0: tag = "R6"; 1: tag = "R3"; 2: tag = "R5"; default: tag = "R4";
    endcase
    chk(rsn == ersn, tag, "reason", rsn, ersn);
    if (ersn != 1) begin
      chk(h == eh, "R1/R2", "handler", h, eh);
      chk(s == es, "R1/R2", "slot", s, es);
    end
  endtask

  task automatic lookup(input logic [7:0] pr, input logic [31:0] ip,
                        input logic [15:0] pt);
    int ersn, eh, es, rsn, h, s, st0;
    expect_res(pr, ip, pt, ersn, eh, es);
    st0 = stat_cnt;
    send_hdr(pr, ip, pt);
    get_res(rsn, h, s);
    cmp_res(rsn, h, s, ersn, eh, es);
    chk((stat_cnt - st0) == (ersn == 3 ? 1 : 0), "R4", "stat pulses",
        stat_cnt - st0, ersn == 3 ? 1 : 0);
    if (ersn == 3) chk(stat_last == eh, "R4", "stat handler", stat_last, eh);
  endtask

  logic [31:0] ips [5] = '{32'h0A010203, 32'h0A010909, 32'h0A020001,
                           32'hC0A80505, 32'h08080808};
  logic [7:0]  prs [3] = '{8'd1, 8'd6, 8'd17};
  logic [15:0] pts [4] = '{16'd0, 16'd53, 16'd80, 16'd443};
  logic [3:0]  ld_p [4] = '{4'hF, 4'hF, 4'b0011, 4'b1010};
  logic [3:0]  fl_p [4] = '{4'h0, 4'b0101, 4'h0, 4'b1100};

  task automatic sweep();
    for (int p = 0; p < 4; p++) begin
      hdl_loaded = ld_p[p]; hdl_full = fl_p[p];
      for (int a = 0; a < 5; a++)
        for (int b = 0; b < 3; b++)
          for (int c = 0; c < 4; c++)
            lookup(prs[b], ips[a], pts[c]);
    end
    hdl_loaded = 4'hF; hdl_full = 4'h0;
  endtask

  initial begin
    int ersn[4], eh[4], es[4];
    int rsn, h, s;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    chk(res_valid == 0, "R11", "res_valid after reset", res_valid, 0);
    chk(hdr_ready == 1, "R11", "hdr_ready after reset", hdr_ready, 1);
    chk(cmd_ready == 1, "R11", "cmd_ready after reset", cmd_ready, 1);
    chk(done_valid == 0, "R11", "done_valid after reset", done_valid, 0);
    lookup(8'd6, 32'h0A010203, 16'd80);   // R11 empty table -> no match

    // R8: fill table, then overflow
    add_rule(8'd6,  32'h0A010000, 32'hFFFF0000, 16'd80,  0, 1);
    add_rule(8'd6,  32'h0A010200, 32'hFFFFFF00, 16'd80,  1, 2);
    add_rule(8'd17, 32'h0A010203, 32'hFFFFFFFF, 16'd53,  2, 3);
    add_rule(8'd1,  32'h00000000, 32'h00000000, 16'd0,   3, 4);
    add_rule(8'd6,  32'hC0A80000, 32'hFFFF0000, 16'd443, 1, 5);
    add_rule(8'd17, 32'h08080808, 32'hFFFFFFFF, 16'd53,  3, 6);
    add_rule(8'd17, 32'h0A000000, 32'hFF000000, 16'd53,  0, 7);
    add_rule(8'd6,  32'h00000000, 32'h00000000, 16'd443, 2, 0);
    add_rule(8'd6,  32'h01020304, 32'hFFFFFFFF, 16'd22,  1, 1);  // table full

    sweep();   // R1 R2 R3 R4 R5 R6

    // R9: deletes, double delete; R8: recycled order
    del_rule(0);
    del_rule(2);
    del_rule(0);
    add_rule(8'd17, 32'h0A010200, 32'hFFFFFF00, 16'd53, 3, 2);
    sweep();   // R2: rule 1 now wins for 10.1.2.x port 80

    // R10: delete posted during a search does not affect it
    hdl_loaded = 4'hF; hdl_full = 4'h0;
    expect_res(8'd6, 32'h0A010205, 16'd80, ersn[0], eh[0], es[0]);
    send_hdr(8'd6, 32'h0A010205, 16'd80);
    del_rule(1);
    get_res(rsn, h, s);
    chk(rsn == ersn[0] && h == eh[0], "R10", "search before write", h, eh[0]);
    lookup(8'd6, 32'h0A010205, 16'd80);   // R10 after write: no match now

    // R7: back-pressure, ordering, queue limit
    hdl_loaded = 4'b0111; hdl_full = 4'b0010;
    expect_res(8'd17, 32'h08080808, 16'd53, ersn[0], eh[0], es[0]);
    expect_res(8'd6,  32'hC0A80101, 16'd443, ersn[1], eh[1], es[1]);
    expect_res(8'd1,  32'h0A0B0C0D, 16'd0,  ersn[2], eh[2], es[2]);
    expect_res(8'd6,  32'h09090909, 16'd443, ersn[3], eh[3], es[3]);
    send_hdr(8'd17, 32'h08080808, 16'd53);
    send_hdr(8'd6,  32'hC0A80101, 16'd443);
    send_hdr(8'd1,  32'h0A0B0C0D, 16'd0);
    send_hdr(8'd6,  32'h09090909, 16'd443);
    repeat (30) @(negedge clk);
    chk(hdr_ready == 0, "R7", "hdr_ready with queue full", hdr_ready, 0);
    chk(res_valid == 1, "R7", "verdict held", res_valid, 1);
    for (int k = 0; k < 4; k++) begin
      get_res(rsn, h, s);
      chk(rsn == ersn[k], "R7", "ordered reason", rsn, ersn[k]);
      if (ersn[k] != 1) chk(h == eh[k], "R7", "ordered handler", h, eh[k]);
    end
    chk(res_valid == 0, "R7", "queue drained", res_valid, 0);
    finish_run();
  end

endmodule